// File: doc/BRIEF.md
# L1 Sharer Tracker and Invalidation-Ack Counter

This block holds the coherence bookkeeping for one line of a shared second-level cache: a bit per first-level cache that currently holds a copy, and the ID of the cache that owns the line exclusively. It turns each incoming first-level request type into a protocol event. Whether the requester is already a sharer decides this for upgrade and putback requests. The surrounding state machine acts on that event.

For every classified request it computes the signed ack count that goes into the data or ack response. It also forms two invalidation destination masks: one for a forwarded write, which skips the requester, and one for a replacement, which covers every sharer. During a replacement a pending-ack counter is loaded with the number of sharers. Each incoming ack subtracts the count it carries, and a flag shows whether that ack finishes the set.

Request classification and ack arithmetic are combinational on the current inputs and the registered sharer state. Sharer edits and counter updates take effect at the next clock edge.

Top module: `sharer_ack_tracker`

## Requirements
- R1: Request type codes are 0 read, 1 instruction fetch, 2 write, 3 upgrade, 4 putback. Read maps to event 0, fetch to event 1 and write to event 2. Codes 5 to 7 map to event 7 (illegal).
- R2: An upgrade (code 3) from a requester whose sharer bit is set gives event 3. From any other requester it gives event 2, a full write.
- R3: A putback (code 4) from a sharer gives event 4. From a non-sharer it gives event 5, a stale putback.
- R4: For a request classified as a write (event 2), resp_ack equals minus the number of set sharer bits, plus one if the requester's bit is set.
- R5: For an upgrade event (event 3), resp_ack equals minus the sharer count plus one.
- R6: Read, fetch, putback, stale putback and illegal events give resp_ack = 0.
- R7: inv_fwd_mask equals the sharer vector with the requester's bit cleared. inv_repl_mask equals the sharer vector.
- R8: A cycle with repl_start high loads pend_acks with the sharer count, visible after that clock edge. repl_start takes priority over ack_valid.
- R9: While ack_valid is high, acks_all is 1 if pend_acks minus ack_count is zero, and acks_some is 1 otherwise. At the edge pend_acks takes that difference.
- R10: own_set makes owner_id equal to req_id and leaves only that requester's bit set in the sharer vector.
- R11: Sharer edits take priority in the order own_set, then clr_sharers, then rm_sharer, then add_sharer. Adding a bit that is already set leaves the vector unchanged. rm_sharer clears the requester's bit.
- R12: After reset the sharer vector, owner_id and pend_acks are zero, and both ack flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_type | input | 3 | Raw request type code |
| req_id | input | ID_W | Requesting first-level cache |
| add_sharer | input | 1 | Set the requester's sharer bit |
| rm_sharer | input | 1 | Clear the requester's sharer bit |
| clr_sharers | input | 1 | Clear all sharer bits |
| own_set | input | 1 | Make the requester the exclusive owner and sole sharer |
| repl_start | input | 1 | Load the pending-ack counter from the sharer count |
| ack_valid | input | 1 | An ack arrives this cycle |
| ack_count | input | CNT_W | Signed count carried by the ack |
| event_code | output | 3 | Classified protocol event |
| resp_ack | output | CNT_W | Signed ack count for the response |
| inv_fwd_mask | output | N_L1 | Invalidation targets for a forwarded write |
| inv_repl_mask | output | N_L1 | Invalidation targets for a replacement |
| sharers | output | N_L1 | Current sharer vector |
| owner_id | output | ID_W | Exclusive owner |
| pend_acks | output | CNT_W | Signed pending-ack counter |
| acks_all | output | 1 | The current ack completes the set |
| acks_some | output | 1 | The current ack leaves acks outstanding |

## Verification
The bench runs on a four-cache configuration. It builds each of the 16 sharer vectors and presents every requester with all eight type codes. This separates sharer-dependent classification (upgrade against write, putback against stale) from fixed classification, and the empty and full vectors expose off-by-one errors in the ack arithmetic and the masks. For every vector, replacement is run by sending single acks until the counter drains, which checks the partial/complete split at each remaining count. A two-count ack and an ack that arrives together with a load test the counter's subtraction and its priority. Directed edits then test ownership, idempotent add, remove and the edit priority.

// File: rtl/sharer_pkg.sv
package sharer_pkg;

    localparam logic [2:0] RQ_READ    = 3'd0;
    localparam logic [2:0] RQ_FETCH   = 3'd1;
    localparam logic [2:0] RQ_WRITE   = 3'd2;
    localparam logic [2:0] RQ_UPGRADE = 3'd3;
    localparam logic [2:0] RQ_PUTBACK = 3'd4;

    typedef enum logic [2:0] {
        EV_READ      = 3'd0,
        EV_FETCH     = 3'd1,
        EV_WRITE     = 3'd2,
        EV_UPGRADE   = 3'd3,
        EV_PUTBACK   = 3'd4,
        EV_PUT_STALE = 3'd5,
        EV_RSVD      = 3'd6,
        EV_ILLEGAL   = 3'd7
    } evt_e;

    typedef struct packed {
        logic add;
        logic rm;
        logic clr;
        logic own;
    } edit_cmd_t;

endpackage

// File: rtl/sharer_vec.sv
module sharer_vec #(
    parameter int N_L1 = 8,
    parameter int ID_W = $clog2(N_L1),
    parameter int CW   = $clog2(N_L1 + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  sharer_pkg::edit_cmd_t  cmd,
    input  logic [ID_W-1:0]        id,
    output logic [N_L1-1:0]        vec,
    output logic [ID_W-1:0]        owner,
    output logic [CW-1:0]          count,
    output logic                   hit
);
    logic [N_L1-1:0] id_bit;

    assign id_bit = N_L1'(1) << id;
    assign hit    = |(vec & id_bit);

    always_comb begin
        count = '0;
        for (int i = 0; i < N_L1; i++) begin
            count = count + CW'(vec[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec   <= '0;
            owner <= '0;
        end else if (cmd.own) begin
            vec   <= id_bit;
            owner <= id;
        end else if (cmd.clr) begin
            vec <= '0;
        end else if (cmd.rm) begin
            vec <= vec & ~id_bit;
        end else if (cmd.add) begin
            vec <= vec | id_bit;
        end
    end
endmodule

// File: rtl/req_classifier.sv
module req_classifier #(
    parameter int N_L1  = 8,
    parameter int ID_W  = $clog2(N_L1),
    parameter int CW    = $clog2(N_L1 + 1),
    parameter int CNT_W = CW + 1
) (
    input  logic [2:0]              req_type,
    input  logic [ID_W-1:0]         id,
    input  logic [N_L1-1:0]         vec,
    input  logic [CW-1:0]           count,
    input  logic                    hit,
    output sharer_pkg::evt_e        evt,
    output logic signed [CNT_W-1:0] ack,
    output logic [N_L1-1:0]         fwd_mask,
    output logic [N_L1-1:0]         repl_mask
);
    import sharer_pkg::*;

    logic signed [CNT_W-1:0] neg_cnt;

    assign neg_cnt   = -$signed({1'b0, count});
    assign fwd_mask  = vec & ~(N_L1'(1) << id);
    assign repl_mask = vec;

    always_comb begin
        case (req_type)
            RQ_READ:    evt = EV_READ;
            RQ_FETCH:   evt = EV_FETCH;
            RQ_WRITE:   evt = EV_WRITE;
            RQ_UPGRADE: evt = hit ? EV_UPGRADE : EV_WRITE;
            RQ_PUTBACK: evt = hit ? EV_PUTBACK : EV_PUT_STALE;
            default:    evt = EV_ILLEGAL;
        endcase
    end

    always_comb begin
        case (evt)
            EV_WRITE:   ack = neg_cnt + $signed(CNT_W'(hit));
            EV_UPGRADE: ack = neg_cnt + $signed(CNT_W'(1));
            default:    ack = '0;
        endcase
    end
endmodule

// File: rtl/ack_counter.sv
module ack_counter #(
    parameter int CW    = 4,
    parameter int CNT_W = CW + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [CW-1:0]           load_val,
    input  logic                    ack_valid,
    input  logic signed [CNT_W-1:0] ack_count,
    output logic signed [CNT_W-1:0] pend,
    output logic                    all_done,
    output logic                    partial
);
    logic signed [CNT_W-1:0] remain;

    assign remain   = pend - ack_count;
    assign all_done = ack_valid && (remain == '0);
    assign partial  = ack_valid && (remain != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (load) begin
            pend <= $signed({1'b0, load_val});
        end else if (ack_valid) begin
            pend <= remain;
        end
    end
endmodule

// File: rtl/sharer_ack_tracker.sv
module sharer_ack_tracker #(
    parameter int N_L1  = 8,
    parameter int ID_W  = $clog2(N_L1),
    parameter int CNT_W = $clog2(N_L1 + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [2:0]              req_type,
    input  logic [ID_W-1:0]         req_id,
    input  logic                    add_sharer,
    input  logic                    rm_sharer,
    input  logic                    clr_sharers,
    input  logic                    own_set,
    input  logic                    repl_start,
    input  logic                    ack_valid,
    input  logic signed [CNT_W-1:0] ack_count,
    output logic [2:0]              event_code,
    output logic signed [CNT_W-1:0] resp_ack,
    output logic [N_L1-1:0]         inv_fwd_mask,
    output logic [N_L1-1:0]         inv_repl_mask,
    output logic [N_L1-1:0]         sharers,
    output logic [ID_W-1:0]         owner_id,
    output logic signed [CNT_W-1:0] pend_acks,
    output logic                    acks_all,
    output logic                    acks_some
);
    import sharer_pkg::*;

    localparam int CW = CNT_W - 1;

    edit_cmd_t       cmd;
    logic [CW-1:0]   sh_count;
    logic            sh_hit;
    evt_e            evt;

    assign cmd = '{add: add_sharer, rm: rm_sharer, clr: clr_sharers, own: own_set};

    sharer_vec #(.N_L1(N_L1), .ID_W(ID_W), .CW(CW)) u_vec (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .id    (req_id),
        .vec   (sharers),
        .owner (owner_id),
        .count (sh_count),
        .hit   (sh_hit)
    );

    req_classifier #(.N_L1(N_L1), .ID_W(ID_W), .CW(CW), .CNT_W(CNT_W)) u_cls (
        .req_type  (req_type),
        .id        (req_id),
        .vec       (sharers),
        .count     (sh_count),
        .hit       (sh_hit),
        .evt       (evt),
        .ack       (resp_ack),
        .fwd_mask  (inv_fwd_mask),
        .repl_mask (inv_repl_mask)
    );

    assign event_code = evt;

    ack_counter #(.CW(CW), .CNT_W(CNT_W)) u_ack (
        .clk       (clk),
        .rst       (rst),
        .load      (repl_start),
        .load_val  (sh_count),
        .ack_valid (ack_valid),
        .ack_count (ack_count),
        .pend      (pend_acks),
        .all_done  (acks_all),
        .partial   (acks_some)
    );
endmodule

// File: rtl/sharer_ack_tracker_chk.sv
module sharer_ack_tracker_chk #(
    parameter int N_L1  = 8,
    parameter int ID_W  = $clog2(N_L1),
    parameter int CNT_W = $clog2(N_L1 + 1) + 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic [2:0]              req_type,
    input logic [ID_W-1:0]         req_id,
    input logic                    own_set,
    input logic                    repl_start,
    input logic                    ack_valid,
    input logic signed [CNT_W-1:0] ack_count,
    input logic [2:0]              event_code,
    input logic signed [CNT_W-1:0] resp_ack,
    input logic [N_L1-1:0]         inv_fwd_mask,
    input logic [N_L1-1:0]         sharers,
    input logic [ID_W-1:0]         owner_id,
    input logic signed [CNT_W-1:0] pend_acks,
    input logic                    acks_all,
    input logic                    acks_some
);
    import sharer_pkg::*;

    p_upgrade_nonsharer_r2: assert property (@(posedge clk) disable iff (rst)
        (req_type == RQ_UPGRADE && !sharers[req_id]) |-> event_code == EV_WRITE);

    p_stale_putback_r3: assert property (@(posedge clk) disable iff (rst)
        (req_type == RQ_PUTBACK && !sharers[req_id]) |-> event_code == EV_PUT_STALE);

    p_reader_zero_ack_r6: assert property (@(posedge clk) disable iff (rst)
        (req_type == RQ_READ || req_type == RQ_FETCH) |-> resp_ack == '0);

    p_fwd_mask_r7: assert property (@(posedge clk) disable iff (rst)
        !inv_fwd_mask[req_id] && ((inv_fwd_mask & ~sharers) == '0));

    p_load_count_r8: assert property (@(posedge clk) disable iff (rst)
        repl_start |=> pend_acks == CNT_W'($countones($past(sharers))));

    p_ack_step_r9: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !repl_start) |=> pend_acks == $past(pend_acks) - $past(ack_count));

    p_ack_flags_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(acks_all && acks_some));

    p_owner_sole_r10: assert property (@(posedge clk) disable iff (rst)
        own_set |=> (owner_id == $past(req_id)) && (sharers == (N_L1'(1) << $past(req_id))));
endmodule

bind sharer_ack_tracker sharer_ack_tracker_chk #(.N_L1(N_L1), .ID_W(ID_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_type     (req_type),
    .req_id       (req_id),
    .own_set      (own_set),
    .repl_start   (repl_start),
    .ack_valid    (ack_valid),
    .ack_count    (ack_count),
    .event_code   (event_code),
    .resp_ack     (resp_ack),
    .inv_fwd_mask (inv_fwd_mask),
    .sharers      (sharers),
    .owner_id     (owner_id),
    .pend_acks    (pend_acks),
    .acks_all     (acks_all),
    .acks_some    (acks_some)
);

// File: tb/tb_sharer_ack_tracker.sv
module tb_sharer_ack_tracker;
    localparam int N     = 4;
    localparam int IW    = 2;
    localparam int CNT_W = 4;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [2:0]              req_type = '0;
    logic [IW-1:0]           req_id = '0;
    logic                    add_sharer = 1'b0, rm_sharer = 1'b0, clr_sharers = 1'b0, own_set = 1'b0;
    logic                    repl_start = 1'b0, ack_valid = 1'b0;
    logic signed [CNT_W-1:0] ack_count = '0;
    logic [2:0]              event_code;
    logic signed [CNT_W-1:0] resp_ack;
    logic [N-1:0]            inv_fwd_mask, inv_repl_mask, sharers;
    logic [IW-1:0]           owner_id;
    logic signed [CNT_W-1:0] pend_acks;
    logic                    acks_all, acks_some;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sharer_ack_tracker #(.N_L1(N), .ID_W(IW), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .req_type(req_type), .req_id(req_id),
        .add_sharer(add_sharer), .rm_sharer(rm_sharer), .clr_sharers(clr_sharers),
        .own_set(own_set), .repl_start(repl_start), .ack_valid(ack_valid),
        .ack_count(ack_count), .event_code(event_code), .resp_ack(resp_ack),
        .inv_fwd_mask(inv_fwd_mask), .inv_repl_mask(inv_repl_mask), .sharers(sharers),
        .owner_id(owner_id), .pend_acks(pend_acks), .acks_all(acks_all), .acks_some(acks_some)
    );

    task automatic check(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        add_sharer = 0; rm_sharer = 0; clr_sharers = 0; own_set = 0;
        repl_start = 0; ack_valid = 0;
    endtask

    task automatic set_vec(input logic [N-1:0] v);
        clr_sharers = 1;
        tick();
        for (int i = 0; i < N; i++) begin
            if (v[i]) begin
                req_id = IW'(i);
                add_sharer = 1;
                tick();
            end
        end
    endtask

    function automatic int popc(input logic [N-1:0] v);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(v[i]);
        return c;
    endfunction

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        // R12: reset state
        check("R12 sharers", int'(sharers), 0);
        check("R12 owner", int'(owner_id), 0);
        check("R12 pend", int'(pend_acks), 0);
        check("R12 flags", int'({acks_all, acks_some}), 0);

        for (int v = 0; v < 16; v++) begin
            set_vec(N'(v));
            check("R11 vector build", int'(sharers), v);
            for (int id = 0; id < N; id++) begin
                for (int t = 0; t < 8; t++) begin
                    int sh, pc, ev, ak;
                    req_type = 3'(t);
                    req_id = IW'(id);
                    #1;
                    sh = (v >> id) & 1;
                    pc = popc(N'(v));
                    case (t)
                        0: ev = 0;
                        1: ev = 1;
                        2: ev = 2;
                        3: ev = sh ? 3 : 2;
                        4: ev = sh ? 4 : 5;
                        default: ev = 7;
                    endcase
                    if (ev == 2) ak = -pc + sh;       // R4
                    else if (ev == 3) ak = -pc + 1;   // R5
                    else ak = 0;                      // R6
                    if (t == 3) check("R2 upgrade class", int'(event_code), ev);
                    else if (t == 4) check("R3 putback class", int'(event_code), ev);
                    else check("R1 type class", int'(event_code), ev);
                    if (ev == 2) check("R4 write ack", int'(resp_ack), ak);
                    else if (ev == 3) check("R5 upgrade ack", int'(resp_ack), ak);
                    else check("R6 zero ack", int'(resp_ack), ak);
                    check("R7 fwd mask", int'(inv_fwd_mask), v & ~(1 << id));
                    check("R7 repl mask", int'(inv_repl_mask), v);
                end
            end
            // R8 / R9: replacement drain with single acks
            repl_start = 1;
            tick();
            check("R8 load", int'(pend_acks), popc(N'(v)));
            for (int k = popc(N'(v)); k > 0; k--) begin
                ack_valid = 1;
                ack_count = 1;
                #1;
                check("R9 all flag", int'(acks_all), (k == 1) ? 1 : 0);
                check("R9 some flag", int'(acks_some), (k == 1) ? 0 : 1);
                tick();
                check("R9 decrement", int'(pend_acks), k - 1);
            end
        end

        // R9: multi-count ack
        set_vec(4'b1110);
        repl_start = 1;
        tick();
        ack_valid = 1; ack_count = 2;
        #1;
        check("R9 some on count 2", int'(acks_some), 1);
        tick();
        check("R9 pend after count 2", int'(pend_acks), 1);
        // R8: load wins over a simultaneous ack
        repl_start = 1; ack_valid = 1; ack_count = 1;
        tick();
        check("R8 load priority", int'(pend_acks), 3);

        // R11: idempotent add, remove, priority
        set_vec(4'b0101);
        req_id = 0; add_sharer = 1;
        tick();
        check("R11 idempotent add", int'(sharers), 5);
        req_id = 0; rm_sharer = 1;
        tick();
        check("R11 remove", int'(sharers), 4);
        req_id = 1; clr_sharers = 1; add_sharer = 1;
        tick();
        check("R11 clear over add", int'(sharers), 0);
        set_vec(4'b0010);
        req_id = 1; rm_sharer = 1; add_sharer = 1;
        tick();
        check("R11 remove over add", int'(sharers), 0);

        // R10: owner marking
        set_vec(4'b1011);
        req_id = 2; own_set = 1; clr_sharers = 1;
        tick();
        check("R10 sole sharer", int'(sharers), 4);
        check("R10 owner id", int'(owner_id), 2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule